// File: doc/BRIEF.md
# CRC authentication engine

This block computes a challenge-response digest for pack authentication. A host writes a 32-bit random challenge into four byte registers, then sets a start bit in a control register. The engine loads a per-device 16-bit seed into a right-shifting, internal-XOR linear feedback shift register. It then shifts in one message bit per clock. The message is the challenge placed above a per-device identifier, and it is fed least-significant bit first. The feedback taps are a per-device 16-bit coefficient word.

When the last bit has been consumed, the 16-bit digest is copied into two read-only result registers and a done flag rises. The host then reads the digest and compares it with the value it computed itself. The identifier, tap word and seed arrive on plain input ports from whatever storage holds them. The register port is a simple byte-wide write strobe with an address, plus a registered read data bus.

Top module: `crc_auth_engine`

## Requirements
- R1: After reset `busy` and `done` are 0, and addresses 0x00 to 0x05 read 0x00.
- R2: A write to the control register at 0x08 with bit 0 set while `busy` is 0 raises `busy` from the next cycle and clears `done`.
- R3: `busy` stays high for exactly MSG_BITS cycles. In the cycle it falls, `done` is 1 and the new digest is readable. `busy` and `done` are never both 1.
- R4: The digest starts from `seed`. For each message bit m[i], i = 0 upward, where m = {challenge, dev_id}: when crc[0] XOR m[i] is 1, crc becomes (crc >> 1) XOR taps; otherwise crc becomes crc >> 1.
- R5: Tap bit 15 is the x^0 coefficient and is treated as 1 whatever its input value, so clearing `poly[15]` leaves the digest unchanged.
- R6: A control write with bit 0 set while `busy` is 1 is ignored: no restart, and completion time is unchanged.
- R7: Challenge byte k sits at address k (k = 0..3) and holds challenge bits [8k+7:8k]. It is written when `busy` is 0. A write to it while `busy` is 1, including the final busy cycle, has no effect.
- R8: The digest low byte reads at 0x04 and the high byte at 0x05. It is cleared only by reset, and bus writes to 0x04 and 0x05 have no effect.
- R9: Reads are registered: `reg_rdata` shows the addressed byte one cycle after `reg_addr` is presented. The control register reads {6'b0, done, busy}, and any unmapped address reads 0xFF.
- R10: `done` stays 1 until the next accepted start. A control write with bit 0 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address for read and write |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Registered read data |
| dev_id | input | MSG_BITS-32 (64) | Per-device identifier, low part of the message |
| poly | input | 16 | Per-device feedback tap word |
| seed | input | 16 | Per-device initial register value |
| busy | output | 1 | Calculation in progress (reads as control bit 0) |
| done | output | 1 | Digest valid (reads as control bit 1) |

## Verification
Two functions can meet in the same cycle: completion of a calculation and a new bus write. A challenge write or a fresh start request may arrive in the final busy cycle, which is the very edge on which the digest lands. The bench counts cycles from the accepted start and places such a write exactly on that last busy cycle. It then confirms that the challenge byte kept its old value, that no restart happened, and that an ordinary start in the first idle cycle is accepted. A behavioural model updated every clock judges `busy`, `done` and the read bus throughout, and directed checks cover the digest against an independently computed value.

// File: rtl/crc_auth_pkg.sv
package crc_auth_pkg;
  localparam int unsigned ADDR_W     = 7;
  localparam int unsigned BYTE_W     = 8;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 7'h08;
  localparam int unsigned CTRL_START = 0;
  localparam int unsigned CTRL_DONE  = 1;
  localparam logic [BYTE_W-1:0] UNMAPPED_BYTE = 8'hFF;
endpackage

// File: rtl/crc_auth_regs.sv
module crc_auth_regs
  import crc_auth_pkg::*;
#(
  parameter int unsigned CHAL_BYTES = 4,
  parameter int unsigned RES_BYTES  = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [BYTE_W-1:0]            wdata,
  input  logic                         busy,
  input  logic                         done,
  input  logic [RES_BYTES*BYTE_W-1:0]  result,
  output logic [CHAL_BYTES*BYTE_W-1:0] challenge,
  output logic                         start,
  output logic [BYTE_W-1:0]            rdata
);
  localparam int unsigned RES_LO = CHAL_BYTES;

  // challenge byte registers, frozen while a calculation runs
  genvar g;
  generate
    for (g = 0; g < CHAL_BYTES; g++) begin : g_chal
      logic [BYTE_W-1:0] byte_q;
      logic              hit;
      assign hit = wr_en && !busy && (addr == ADDR_W'(g));
      always_ff @(posedge clk) begin
        if (rst)      byte_q <= '0;
        else if (hit) byte_q <= wdata;
      end
      assign challenge[g*BYTE_W +: BYTE_W] = byte_q;
    end
  endgenerate

  assign start = wr_en && !busy && (addr == CTRL_ADDR) && wdata[CTRL_START];

  logic [BYTE_W-1:0] rd_nxt;
  always_comb begin
    rd_nxt = UNMAPPED_BYTE;
    for (int i = 0; i < CHAL_BYTES; i++)
      if (addr == ADDR_W'(i)) rd_nxt = challenge[i*BYTE_W +: BYTE_W];
    for (int i = 0; i < RES_BYTES; i++)
      if (addr == ADDR_W'(RES_LO + i)) rd_nxt = result[i*BYTE_W +: BYTE_W];
    if (addr == CTRL_ADDR) begin
      rd_nxt             = '0;
      rd_nxt[CTRL_START] = busy;
      rd_nxt[CTRL_DONE]  = done;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nxt;
  end
endmodule

// File: rtl/crc_auth_core.sv
module crc_auth_core #(
  parameter int unsigned MSG_BITS = 96,
  parameter int unsigned CRC_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [MSG_BITS-1:0] msg,
  input  logic [CRC_W-1:0]    poly,
  input  logic [CRC_W-1:0]    seed,
  output logic                busy,
  output logic                done,
  output logic [CRC_W-1:0]    result
);
  localparam int unsigned CNT_W = (MSG_BITS > 1) ? $clog2(MSG_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MSG_BITS - 1);
  localparam logic [CRC_W-1:0] X0_TAP = {1'b1, {(CRC_W-1){1'b0}}};

  logic [CRC_W-1:0] lfsr_q, lfsr_nxt, taps;
  logic [CNT_W-1:0] idx_q;
  logic             fb;

  // the x^0 coefficient sits in the top tap bit and is always present
  assign taps     = poly | X0_TAP;
  assign fb       = lfsr_q[0] ^ msg[idx_q];
  assign lfsr_nxt = (lfsr_q >> 1) ^ (fb ? taps : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_q <= '0;
      idx_q  <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
    end else if (!busy) begin
      if (start) begin
        lfsr_q <= seed;
        idx_q  <= '0;
        busy   <= 1'b1;
        done   <= 1'b0;
      end
    end else begin
      lfsr_q <= lfsr_nxt;
      idx_q  <= idx_q + 1'b1;
      if (idx_q == LAST_IDX) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        result <= lfsr_nxt;
      end
    end
  end
endmodule

// File: rtl/crc_auth_engine.sv
module crc_auth_engine
  import crc_auth_pkg::*;
#(
  parameter int unsigned MSG_BITS   = 96,
  parameter int unsigned CRC_W      = 16,
  parameter int unsigned CHAL_BYTES = 4,
  localparam int unsigned ID_W      = MSG_BITS - CHAL_BYTES*BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic [ID_W-1:0]   dev_id,
  input  logic [CRC_W-1:0]  poly,
  input  logic [CRC_W-1:0]  seed,
  output logic              busy,
  output logic              done
);
  localparam int unsigned RES_BYTES = CRC_W / BYTE_W;
  localparam int unsigned CHAL_W    = CHAL_BYTES * BYTE_W;

  logic [CHAL_W-1:0] challenge;
  logic [CRC_W-1:0]  core_result;
  logic              start;

  crc_auth_regs #(
    .CHAL_BYTES(CHAL_BYTES),
    .RES_BYTES (RES_BYTES)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .busy     (busy),
    .done     (done),
    .result   (core_result),
    .challenge(challenge),
    .start    (start),
    .rdata    (reg_rdata)
  );

  crc_auth_core #(
    .MSG_BITS(MSG_BITS),
    .CRC_W   (CRC_W)
  ) u_core (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .msg   ({challenge, dev_id}),
    .poly  (poly),
    .seed  (seed),
    .busy  (busy),
    .done  (done),
    .result(core_result)
  );
endmodule

// File: rtl/crc_auth_checker.sv
module crc_auth_checker
  import crc_auth_pkg::*;
#(
  parameter int unsigned MSG_BITS = 96,
  parameter int unsigned CRC_W    = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              start_bit,
  input logic              busy,
  input logic              done,
  input logic [CRC_W-1:0]  result
);
  int unsigned run_len;
  always_ff @(posedge clk) begin
    if (rst)       run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  a_r2_start_accepted: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && reg_addr == CTRL_ADDR && start_bit && !busy) |=> (busy && !done));

  a_r3_exclusive_flags: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  a_r3_done_with_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $fell(busy));

  a_r6_run_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == MSG_BITS));

  a_r6_no_overrun: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_len < MSG_BITS));

  a_r8_result_held: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(result));
endmodule

bind crc_auth_engine crc_auth_checker #(
  .MSG_BITS(MSG_BITS),
  .CRC_W   (CRC_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_wr_en(reg_wr_en),
  .reg_addr (reg_addr),
  .start_bit(reg_wdata[0]),
  .busy     (busy),
  .done     (done),
  .result   (core_result)
);

// File: tb/crc_auth_engine_bench.sv
`timescale 1ns/1ps
module crc_auth_engine_bench;
  localparam int MSG_BITS = 96;
  localparam int ID_W     = 64;

  logic        clk = 1'b0, rst = 1'b1, wr = 1'b0;
  logic [6:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [ID_W-1:0] dev_id;
  logic [15:0] poly, seed;
  logic        busy, done;

  int checks = 0, errors = 0, cyc = 0;
  bit live = 0;

  always #4 clk = ~clk;

  crc_auth_engine u_crc_auth_engine (
    .clk(clk), .rst(rst), .reg_wr_en(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .dev_id(dev_id), .poly(poly), .seed(seed),
    .busy(busy), .done(done)
  );

  function automatic logic [15:0] ref_crc(logic [31:0] ch, logic [ID_W-1:0] id,
                                          logic [15:0] p, logic [15:0] s);
    logic [MSG_BITS-1:0] m = {ch, id};
    logic [15:0] c = s;
    logic [15:0] pe = p | 16'h8000;
    for (int i = 0; i < MSG_BITS; i++) begin
      if (c[0] ^ m[i]) c = (c >> 1) ^ pe;
      else             c = c >> 1;
    end
    return c;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference, updated on every clock
  bit          m_busy, m_done;
  int          m_left;
  logic [7:0]  m_chal [4];
  logic [15:0] m_res, m_pend;
  logic [7:0]  m_rd;

  always @(posedge clk) begin : model
    logic [7:0] nrd;
    bit ob;
    cyc++;
    if (rst) begin
      m_busy = 0; m_done = 0; m_left = 0; m_res = '0; m_pend = '0; m_rd = '0;
      for (int k = 0; k < 4; k++) m_chal[k] = '0;
    end else begin
      nrd = 8'hFF;
      if (addr < 4)       nrd = m_chal[addr[1:0]];
      else if (addr == 4) nrd = m_res[7:0];
      else if (addr == 5) nrd = m_res[15:8];
      else if (addr == 8) nrd = {6'b0, m_done, m_busy};
      ob = m_busy;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin m_busy = 0; m_done = 1; m_res = m_pend; end
      end else if (wr && addr == 8 && wdata[0]) begin
        m_busy = 1; m_done = 0; m_left = MSG_BITS;
        m_pend = ref_crc({m_chal[3], m_chal[2], m_chal[1], m_chal[0]}, dev_id, poly, seed);
      end
      if (wr && !ob && addr < 4) m_chal[addr[1:0]] = wdata;
      m_rd = nrd;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      chk(busy == m_busy, "R3 busy vs model", int'(busy), int'(m_busy));
      chk(done == m_done, "R3 done vs model", int'(done), int'(m_done));
      chk(rdata == m_rd, "R9 rdata vs model", int'(rdata), int'(m_rd));
    end
  end

  task automatic wr_reg(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic rd_res(output logic [15:0] r);
    logic [7:0] lo, hi;
    rd_reg(7'h04, lo); rd_reg(7'h05, hi);
    r = {hi, lo};
  endtask

  task automatic load_chal(input logic [31:0] ch);
    for (int k = 0; k < 4; k++) wr_reg(7'(k), ch[k*8 +: 8]);
  endtask

  task automatic run_auth();
    wr_reg(7'h08, 8'h01);
    while (busy) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [7:0]  d;
    logic [15:0] r, r_a;
    int t0;
    dev_id = 64'h65a9b4f38dcc217d; poly = 16'hA410; seed = 16'h6A9F;
    repeat (4) @(negedge clk);
    rst = 1'b0; live = 1;

    chk(busy == 0, "R1 busy after reset", int'(busy), 0);
    chk(done == 0, "R1 done after reset", int'(done), 0);
    for (int k = 0; k < 6; k++) begin
      rd_reg(7'(k), d);
      chk(d == 8'h00, "R1 register clear", int'(d), 0);
    end

    rd_reg(7'h30, d); chk(d == 8'hFF, "R9 unmapped 0x30", int'(d), 'hFF);
    rd_reg(7'h7F, d); chk(d == 8'hFF, "R9 unmapped 0x7F", int'(d), 'hFF);
    rd_reg(7'h08, d); chk(d == 8'h00, "R9 control idle", int'(d), 0);

    load_chal(32'ha0071d8e);
    rd_reg(7'h00, d); chk(d == 8'h8e, "R7 byte0", int'(d), 'h8e);
    rd_reg(7'h03, d); chk(d == 8'ha0, "R7 byte3", int'(d), 'ha0);

    // start, then poke the block while busy
    wr_reg(7'h08, 8'h01);
    t0 = cyc;
    chk(busy == 1, "R2 busy after start", int'(busy), 1);
    chk(done == 0, "R2 done cleared", int'(done), 0);
    wr_reg(7'h08, 8'h01);            // R6 restart attempt
    wr_reg(7'h00, 8'h55);            // R7 blocked write
    wr_reg(7'h04, 8'h12);            // R8 result write
    while (busy) @(negedge clk);
    chk(cyc - t0 == MSG_BITS, "R6 run length unchanged", cyc - t0, MSG_BITS);
    chk(done == 1, "R3 done at completion", int'(done), 1);
    rd_res(r_a);
    chk(r_a == ref_crc(32'ha0071d8e, dev_id, poly, seed), "R4 check vector digest",
        int'(r_a), int'(ref_crc(32'ha0071d8e, dev_id, poly, seed)));
    rd_reg(7'h00, d); chk(d == 8'h8e, "R7 write during busy blocked", int'(d), 'h8e);
    rd_reg(7'h08, d); chk(d == 8'h02, "R9 control reads done", int'(d), 2);

    wr_reg(7'h08, 8'h00);
    chk(done == 1, "R10 clear-bit write no effect", int'(done), 1);
    chk(busy == 0, "R10 no start from zero write", int'(busy), 0);
    wr_reg(7'h04, 8'h00); wr_reg(7'h05, 8'hAB);
    rd_res(r); chk(r == r_a, "R8 result not writable", int'(r), int'(r_a));

    poly = 16'hA410 & 16'h7FFF;
    run_auth();
    rd_res(r); chk(r == r_a, "R5 top tap forced", int'(r), int'(r_a));

    for (int p = 0; p < 4; p++) begin
      logic [31:0] ch;
      ch     = 32'h9E3779B9 * (p + 1);
      dev_id = {ch ^ 32'h0123_4567, ~ch};
      seed   = 16'(p * 16'h1D0F);
      poly   = 16'h8408 ^ 16'(p * 16'h0421);
      load_chal(ch);
      run_auth();
      rd_res(r);
      chk(r == ref_crc(ch, dev_id, poly, seed), "R4 pattern digest",
          int'(r), int'(ref_crc(ch, dev_id, poly, seed)));
    end

    // collision: challenge write on the final busy cycle
    load_chal(32'h11223344);
    wr_reg(7'h08, 8'h01);
    t0 = cyc;
    while (cyc - t0 < MSG_BITS - 1) @(negedge clk);
    wr = 1'b1; addr = 7'h01; wdata = 8'hC3;
    @(negedge clk); wr = 1'b0;
    chk(busy == 0, "R3 busy fell on schedule", int'(busy), 0);
    chk(done == 1, "R3 done on completion edge", int'(done), 1);
    rd_reg(7'h01, d); chk(d == 8'h33, "R7 last-cycle write blocked", int'(d), 'h33);

    // collision: start request on the final busy cycle
    wr_reg(7'h08, 8'h01);
    t0 = cyc;
    chk(busy == 1, "R2 start in first idle cycle", int'(busy), 1);
    while (cyc - t0 < MSG_BITS - 1) @(negedge clk);
    wr = 1'b1; addr = 7'h08; wdata = 8'h01;
    @(negedge clk); wr = 1'b0;
    chk(busy == 0, "R6 last-cycle start ignored", int'(busy), 0);
    chk(done == 1, "R10 done held", int'(done), 1);
    rd_res(r);
    chk(r == ref_crc(32'h11223344, dev_id, poly, seed), "R4 collision digest",
        int'(r), int'(ref_crc(32'h11223344, dev_id, poly, seed)));

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule